// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR-style flash bus and carries out one program or erase operation for each request. A request names the operation, a target address and, for a program, a data word. The sequencer then issues the protected write sequence on the bus: two unlock writes and a command write, followed by either the data write or a second unlock pair and the erase command. Each bus write is a chip-enable window with a timed write-strobe pulse inside it. Setup, pulse width and recovery are parameters counted in clock cycles.

Once the last write is sent, the sequencer reads the target location repeatedly. A read counts as a completion candidate when the polarity bit matches the expected value or the toggle bit has stopped changing since the previous read. A candidate word that is not the expected word can be a read that landed at the moment the write finished. For such a word the sequencer reads the location two more times before it decides. Polling stops with an error once an operation-specific cycle limit is reached. The result comes back as a one-cycle done pulse and an error flag.

Top module: `flash_pe_seq`

## Requirements
- R1: Request operation code 0 (program) produces exactly four bus writes: address 0x5555 data 0xAA, address 0x2AAA data 0x55, address 0x5555 data 0xA0, then the request address with the request data.
- R2: Operation codes 1 (sector erase), 2 (block erase) and 3 (chip erase) produce exactly six bus writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55. The sixth write is request address/0x30 for code 1, request address/0x50 for code 2 and 0x5555/0x10 for code 3.
- R3: The write strobe goes low only while chip enable is low and output enable is high. It stays low for at least WE_LOW_CYC cycles and stays high for at least WE_HIGH_CYC cycles between two pulses. Address and data out do not change while the strobe is low or in the cycle in which it rises.
- R4: Status reads hold chip enable and output enable low together for at least RD_CYC cycles with the write strobe high, and no bus write occurs during polling.
- R5: A read is a completion candidate when its bit 7 equals bit 7 of the expected word, or when its bit 6 equals bit 6 of the previous read of the same operation. The expected word is the request data for a program and all ones for an erase. A candidate equal to the expected word ends the operation with no error and no further reads.
- R6: A candidate that differs from the expected word causes exactly two further reads. The operation ends without error only if both of those reads equal the expected word; otherwise it ends with error.
- R7: A program whose polling reaches TO_PROG_CYC cycles without completing ends with error. No program ends with error through this limit before it is reached.
- R8: Sector and block erase use the limit TO_ERASE_CYC and chip erase uses TO_CHIP_CYC, with the same rule as R7.
- R9: done is high for exactly one cycle per operation. error is valid in that cycle and holds its value until the next accepted request.
- R10: A start request that arrives while an operation is in progress is ignored: it produces no bus writes and changes neither the running operation nor its result.
- R11: During and right after reset, chip enable, output enable and write strobe are high, and done and error are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_start | input | 1 | One-cycle request to begin an operation |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Result of the last operation: 1 on time-out or confirmed mismatch |
| bus_addr | output | AW | Flash address bus |
| bus_dout | output | DW | Flash write data |
| bus_din | input | DW | Flash read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write strobe, active low |

## Verification
A wrong write-sequence index or operation latch appears at the bus at the very next write strobe, as a wrong address or code in the unlock stream, and is compared write by write. A bad decision in the polling logic shows up in the number of reads a location receives after the device model reports completion: zero extra reads for a clean result and exactly two for a candidate that mismatches. The bench counts these reads, so a decision error is seen within one read period of completion. A broken limit counter shows up either as an error pulse before the limit or as no done at all, which the bench catches within a few hundred cycles of the limit.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_CHIP   = 2'd3
  } fop_e;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

  localparam logic [7:0] CODE_KEY1   = 8'hAA;
  localparam logic [7:0] CODE_KEY2   = 8'h55;
  localparam logic [7:0] CODE_WRITE  = 8'hA0;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_SECTOR = 8'h30;
  localparam logic [7:0] CODE_BLOCK  = 8'h50;
  localparam logic [7:0] CODE_CHIP   = 8'h10;

endpackage

// File: rtl/fseq_cmd_gen.sv
module fseq_cmd_gen
  import fseq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  fop_e          op,
  input  logic [2:0]    idx,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_data,
  output logic          last
);

  localparam logic [AW-1:0] ADR_A = AW'(KEY_ADDR_A);
  localparam logic [AW-1:0] ADR_B = AW'(KEY_ADDR_B);

  always_comb begin
    cyc_addr = ADR_A;
    cyc_data = DW'(CODE_KEY1);
    if (op == OP_PROG) begin
      last = (idx == 3'd3);
      unique case (idx)
        3'd0:    begin cyc_addr = ADR_A;    cyc_data = DW'(CODE_KEY1);  end
        3'd1:    begin cyc_addr = ADR_B;    cyc_data = DW'(CODE_KEY2);  end
        3'd2:    begin cyc_addr = ADR_A;    cyc_data = DW'(CODE_WRITE); end
        default: begin cyc_addr = tgt_addr; cyc_data = tgt_data;        end
      endcase
    end else begin
      last = (idx == 3'd5);
      unique case (idx)
        3'd0:    begin cyc_addr = ADR_A; cyc_data = DW'(CODE_KEY1);  end
        3'd1:    begin cyc_addr = ADR_B; cyc_data = DW'(CODE_KEY2);  end
        3'd2:    begin cyc_addr = ADR_A; cyc_data = DW'(CODE_ERASE); end
        3'd3:    begin cyc_addr = ADR_A; cyc_data = DW'(CODE_KEY1);  end
        3'd4:    begin cyc_addr = ADR_B; cyc_data = DW'(CODE_KEY2);  end
        default: begin
          unique case (op)
            OP_SECTOR: begin cyc_addr = tgt_addr; cyc_data = DW'(CODE_SECTOR); end
            OP_BLOCK:  begin cyc_addr = tgt_addr; cyc_data = DW'(CODE_BLOCK);  end
            default:   begin cyc_addr = ADR_A;    cyc_data = DW'(CODE_CHIP);   end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/fseq_bus_phy.sv
module fseq_bus_phy #(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int WE_LOW_CYC  = 4,
  parameter int WE_HIGH_CYC = 3,
  parameter int RD_CYC      = 7,
  parameter int RD_GAP_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_wr,
  input  logic          go_rd,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          idle,
  output logic          ack,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n
);

  localparam int M_A  = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int M_B  = (RD_CYC > RD_GAP_CYC) ? RD_CYC : RD_GAP_CYC;
  localparam int M_AB = (M_A > M_B) ? M_A : M_B;
  localparam int CW   = $clog2(M_AB + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_WSET, PH_WLOW, PH_WHIGH, PH_RLOW, PH_RGAP
  } phase_e;

  phase_e        ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic [DW-1:0] rdq_q, rdq_n;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    data_n = data_q;
    rdq_n  = rdq_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (go_wr) begin
          ph_n   = PH_WSET;
          addr_n = in_addr;
          data_n = in_data;
        end else if (go_rd) begin
          ph_n   = PH_RLOW;
          addr_n = in_addr;
          cnt_n  = CW'(RD_CYC - 1);
        end
      end
      PH_WSET: begin
        ph_n  = PH_WLOW;
        cnt_n = CW'(WE_LOW_CYC - 1);
      end
      PH_WLOW: begin
        if (cnt_q == '0) begin
          ph_n  = PH_WHIGH;
          cnt_n = CW'(WE_HIGH_CYC - 1);
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      PH_WHIGH: begin
        if (cnt_q == '0) ph_n = PH_IDLE;
        else             cnt_n = cnt_q - 1'b1;
      end
      PH_RLOW: begin
        if (cnt_q == '0) begin
          rdq_n = bus_din;
          ph_n  = PH_RGAP;
          cnt_n = CW'(RD_GAP_CYC - 1);
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) ph_n = PH_IDLE;
        else             cnt_n = cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      rdq_q  <= '0;
    end else begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      data_q <= data_n;
      rdq_q  <= rdq_n;
    end
  end

  assign idle     = (ph_q == PH_IDLE);
  assign ack      = ((ph_q == PH_WHIGH) || (ph_q == PH_RGAP)) && (cnt_q == '0);
  assign rd_data  = rdq_q;
  assign bus_addr = addr_q;
  assign bus_dout = data_q;
  assign ce_n     = (ph_q == PH_IDLE) || (ph_q == PH_RGAP);
  assign oe_n     = (ph_q != PH_RLOW);
  assign we_n     = (ph_q != PH_WLOW);

  // Checker state: length of the current low strobe run
  logic [CW:0] lw_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lw_run_q <= '0;
    else if (!we_n) lw_run_q <= lw_run_q + 1'b1;
    else            lw_run_q <= '0;
  end

  a_r3_we_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);
  a_r4_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  a_r3_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !$past(we_n)) |-> ($stable(bus_addr) && $stable(bus_dout)));
  a_r3_hold_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(bus_addr) && $stable(bus_dout)));
  a_r3_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (lw_run_q >= (CW+1)'(WE_LOW_CYC)));

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int TW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_n;

  assign expired = (cnt_q >= limit);

  always_comb begin
    cnt_n = cnt_q;
    if (clr)                 cnt_n = '0;
    else if (run && !expired) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import fseq_pkg::*;
#(
  parameter int AW           = 20,
  parameter int DW           = 16,
  parameter int WE_LOW_CYC   = 4,
  parameter int WE_HIGH_CYC  = 3,
  parameter int RD_CYC       = 7,
  parameter int RD_GAP_CYC   = 2,
  parameter int TO_PROG_CYC  = 1600,
  parameter int TO_ERASE_CYC = 2500000,
  parameter int TO_CHIP_CYC  = 6400000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  output logic          bus_ce_n,
  output logic          bus_oe_n,
  output logic          bus_we_n
);

  localparam int TO_MAX0 = (TO_PROG_CYC > TO_ERASE_CYC) ? TO_PROG_CYC : TO_ERASE_CYC;
  localparam int TO_MAX  = (TO_MAX0 > TO_CHIP_CYC) ? TO_MAX0 : TO_CHIP_CYC;
  localparam int TW      = $clog2(TO_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_POLL} seq_e;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  seq_e          st_q, st_n;
  fop_e          op_q, op_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic [2:0]    idx_q, idx_n;
  logic          hprev_q, hprev_n;
  logic          prev6_q, prev6_n;
  logic [1:0]    conf_q, conf_n;
  logic          ok1_q, ok1_n;
  logic          done_q, done_n;
  logic          err_q, err_n;

  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;
  logic          cyc_last;
  logic          phy_idle, phy_ack;
  logic [DW-1:0] rd_word;
  logic          go_wr, go_rd;
  logic          to_clr, to_run, to_exp;
  logic [TW-1:0] to_limit;
  logic [DW-1:0] exp_word;
  logic          looks_done;

  fseq_cmd_gen #(.AW(AW), .DW(DW)) u_cmd (
    .op       (op_q),
    .idx      (idx_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .cyc_addr (cyc_addr),
    .cyc_data (cyc_data),
    .last     (cyc_last)
  );

  fseq_bus_phy #(
    .AW(AW), .DW(DW), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
    .RD_CYC(RD_CYC), .RD_GAP_CYC(RD_GAP_CYC)
  ) u_phy (
    .clk      (clk),
    .rst_n    (rst_ni),
    .go_wr    (go_wr),
    .go_rd    (go_rd),
    .in_addr  ((st_q == S_POLL) ? addr_q : cyc_addr),
    .in_data  (cyc_data),
    .idle     (phy_idle),
    .ack      (phy_ack),
    .rd_data  (rd_word),
    .bus_addr (bus_addr),
    .bus_dout (bus_dout),
    .bus_din  (bus_din),
    .ce_n     (bus_ce_n),
    .oe_n     (bus_oe_n),
    .we_n     (bus_we_n)
  );

  always_comb begin
    unique case (op_q)
      OP_PROG: to_limit = TW'(TO_PROG_CYC);
      OP_CHIP: to_limit = TW'(TO_CHIP_CYC);
      default: to_limit = TW'(TO_ERASE_CYC);
    endcase
  end

  fseq_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_ni),
    .clr     (to_clr),
    .run     (to_run),
    .limit   (to_limit),
    .expired (to_exp)
  );

  assign exp_word   = (op_q == OP_PROG) ? data_q : {DW{1'b1}};
  assign go_wr      = (st_q == S_CMD)  && phy_idle;
  assign go_rd      = (st_q == S_POLL) && phy_idle;
  assign to_clr     = (st_q == S_CMD) && phy_ack && cyc_last;
  assign to_run     = (st_q == S_POLL);
  assign looks_done = (rd_word[7] == exp_word[7]) || (hprev_q && (rd_word[6] == prev6_q));

  always_comb begin
    st_n    = st_q;
    op_n    = op_q;
    addr_n  = addr_q;
    data_n  = data_q;
    idx_n   = idx_q;
    hprev_n = hprev_q;
    prev6_n = prev6_q;
    conf_n  = conf_q;
    ok1_n   = ok1_q;
    done_n  = 1'b0;
    err_n   = err_q;
    unique case (st_q)
      S_IDLE: begin
        if (req_start) begin
          st_n   = S_CMD;
          op_n   = fop_e'(req_op);
          addr_n = req_addr;
          data_n = req_data;
          idx_n  = 3'd0;
          err_n  = 1'b0;
        end
      end
      S_CMD: begin
        if (phy_ack) begin
          if (cyc_last) begin
            st_n    = S_POLL;
            hprev_n = 1'b0;
            conf_n  = 2'd0;
          end else begin
            idx_n = idx_q + 3'd1;
          end
        end
      end
      default: begin
        if (phy_ack) begin
          if (to_exp) begin
            st_n = S_IDLE; done_n = 1'b1; err_n = 1'b1;
          end else if (conf_q == 2'd1) begin
            ok1_n  = (rd_word == exp_word);
            conf_n = 2'd2;
          end else if (conf_q == 2'd2) begin
            st_n = S_IDLE; done_n = 1'b1;
            err_n = !(ok1_q && (rd_word == exp_word));
          end else if (looks_done) begin
            if (rd_word == exp_word) begin
              st_n = S_IDLE; done_n = 1'b1; err_n = 1'b0;
            end else begin
              conf_n = 2'd1;
            end
          end else begin
            hprev_n = 1'b1;
            prev6_n = rd_word[6];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      hprev_q <= 1'b0;
      prev6_q <= 1'b0;
      conf_q  <= '0;
      ok1_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      op_q    <= op_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      idx_q   <= idx_n;
      hprev_q <= hprev_n;
      prev6_q <= prev6_n;
      conf_q  <= conf_n;
      ok1_q   <= ok1_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign done  = done_q;
  assign error = err_q;

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  a_r9_error_with_done: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(error) |-> done);
  a_r10_busy_keeps_req: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q != S_IDLE && req_start) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));
  a_r4_no_write_in_poll: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_POLL) |-> bus_we_n);

endmodule

// File: tb/flash_pe_seq_test.sv
`timescale 1ns/1ps
module flash_pe_seq_test;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int WE_LOW_CYC  = 4;
  localparam int WE_HIGH_CYC = 3;
  localparam int RD_CYC      = 7;
  localparam int RD_GAP_CYC  = 2;
  localparam int TO_PROG     = 1600;
  localparam int TO_ERASE    = 3000;
  localparam int TO_CHIP     = 5000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_start = 1'b0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          done, error;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din;
  logic          bus_ce_n, bus_oe_n, bus_we_n;

  always #5 clk = ~clk;

  flash_pe_seq #(
    .AW(AW), .DW(DW), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
    .RD_CYC(RD_CYC), .RD_GAP_CYC(RD_GAP_CYC), .TO_PROG_CYC(TO_PROG),
    .TO_ERASE_CYC(TO_ERASE), .TO_CHIP_CYC(TO_CHIP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .done(done), .error(error),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Configuration written only by the stimulus side
  int            cfg_gen = 0;
  int            cfg_need = 4;
  int            cfg_mode = 0;
  int            cfg_blen = 50;
  logic [DW-1:0] cfg_exp = '0;

  // Flash model state, written only by the model process
  int            seen_gen = 0;
  int            m_wr = 0, m_reads = 0, m_post = 0, m_busy = 1;
  int            m_viol = 0, min_low = 999, min_high = 999, min_oe = 999;
  int            lowrun = 0, highrun = 0, oerun = 0;
  logic          m_t6 = 1'b0;
  logic [DW-1:0] m_dq = '0;
  logic [AW-1:0] log_a [0:7];
  logic [DW-1:0] log_d [0:7];
  logic          pw = 1'b1, po = 1'b1;
  logic [AW-1:0] pa = '0;
  logic [DW-1:0] pd = '0;

  assign bus_din = m_dq;

  always @(negedge clk) begin
    if (seen_gen != cfg_gen) begin
      seen_gen = cfg_gen;
      m_wr = 0; m_reads = 0; m_post = 0; m_busy = 1;
      m_viol = 0; min_low = 999; min_high = 999; min_oe = 999;
      lowrun = 0; highrun = 0; oerun = 0;
    end
    if (!bus_we_n && !bus_oe_n) m_viol++;
    if (!bus_we_n && bus_ce_n) m_viol++;
    if (!bus_oe_n && bus_ce_n) m_viol++;
    if (!bus_we_n && !pw && (bus_addr != pa || bus_dout != pd)) m_viol++;
    if (!bus_we_n) begin
      if (pw) begin
        lowrun = 1;
        if (m_wr > 0 && highrun < min_high) min_high = highrun;
      end else lowrun++;
    end else if (!pw) begin
      if (bus_addr != pa || bus_dout != pd) m_viol++;
      if (lowrun < min_low) min_low = lowrun;
      if (m_wr < 8) begin log_a[m_wr] = bus_addr; log_d[m_wr] = bus_dout; end
      m_wr++;
      highrun = 1;
      if (m_wr == cfg_need) m_busy = cfg_blen;
    end else highrun++;
    if (!bus_oe_n) oerun++;
    else if (!po) begin
      if (oerun < min_oe) min_oe = oerun;
      oerun = 0;
    end
    if (!bus_oe_n && po) begin
      m_reads++;
      if (m_wr < cfg_need) m_viol++;
      if (m_busy != 0 || cfg_mode == 3) begin
        m_t6 = ~m_t6;
        m_dq = DW'($urandom);
        m_dq[7] = ~cfg_exp[7];
        m_dq[6] = m_t6;
      end else begin
        if (m_post == 0) m_post = m_reads;
        case (cfg_mode)
          1: m_dq = (m_post == m_reads) ? (cfg_exp ^ 16'h0001) : cfg_exp;
          2: m_dq = cfg_exp ^ 16'h0100;
          4: begin
            m_dq = cfg_exp;
            if (m_post == m_reads) begin
              m_dq[7] = ~cfg_exp[7];
              m_dq[6] = m_t6;
            end
          end
          default: m_dq = cfg_exp;
        endcase
      end
    end
    if (m_busy > 0 && m_wr >= cfg_need) m_busy--;
    pw = bus_we_n; po = bus_oe_n; pa = bus_addr; pd = bus_dout;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [AW-1:0] f_addr(int op, int i, logic [AW-1:0] a);
    if (op == 0) begin
      if (i == 0 || i == 2) return AW'(16'h5555);
      if (i == 1) return AW'(16'h2AAA);
      return a;
    end
    if (i == 1 || i == 4) return AW'(16'h2AAA);
    if (i < 5 || op == 3) return AW'(16'h5555);
    return a;
  endfunction

  function automatic logic [DW-1:0] f_data(int op, int i, logic [DW-1:0] d);
    if (op == 0) begin
      case (i)
        0: return DW'(8'hAA);
        1: return DW'(8'h55);
        2: return DW'(8'hA0);
        default: return d;
      endcase
    end
    case (i)
      0, 3: return DW'(8'hAA);
      1, 4: return DW'(8'h55);
      2: return DW'(8'h80);
      default: return (op == 1) ? DW'(8'h30) : ((op == 2) ? DW'(8'h50) : DW'(8'h10));
    endcase
  endfunction

  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int mode, input int blen, input bit intrude,
                        input bit exp_err, output int el);
    bit   got;
    logic er;
    string rq;
    rq = (op == 0) ? "R1" : "R2";
    @(posedge clk); #1;
    cfg_need = (op == 0) ? 4 : 6;
    cfg_exp  = (op == 0) ? d : '1;
    cfg_mode = mode;
    cfg_blen = blen;
    cfg_gen++;
    @(posedge clk); #1;
    req_op = op[1:0]; req_addr = a; req_data = d; req_start = 1'b1;
    @(posedge clk); #1;
    req_start = 1'b0;
    el = 0; got = 0;
    for (int k = 0; k < 20000 && !got; k++) begin
      @(negedge clk);
      el++;
      if (intrude && k == 8) begin
        req_op = 2'd3; req_addr = ~a; req_data = ~d; req_start = 1'b1;
      end
      if (intrude && k == 9) req_start = 1'b0;
      if (done) got = 1;
    end
    chk(got, "R9", "done seen", got, 1);
    er = error;
    chk(er == exp_err, (mode == 3) ? "R7" : "R6", "error at done", er, exp_err);
    @(negedge clk);
    chk(!done, "R9", "done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(error == er, "R9", "error held", error, er);
    chk(m_wr == cfg_need, intrude ? "R10" : rq, "write count", m_wr, cfg_need);
    for (int i = 0; i < cfg_need; i++) begin
      chk(log_a[i] == f_addr(op, i, a), intrude ? "R10" : rq, "write address", log_a[i], f_addr(op, i, a));
      chk(log_d[i] == f_data(op, i, d), intrude ? "R10" : rq, "write data", log_d[i], f_data(op, i, d));
    end
    chk(min_low >= WE_LOW_CYC, "R3", "strobe low width", min_low, WE_LOW_CYC);
    if (cfg_need > 1)
      chk(min_high >= WE_HIGH_CYC, "R3", "strobe high gap", min_high, WE_HIGH_CYC);
    chk(m_viol == 0, "R3", "bus rule violations", m_viol, 0);
    chk(min_oe >= RD_CYC, "R4", "read window", min_oe, RD_CYC);
    if (mode != 3) begin
      chk(m_post > 0 && m_reads == m_post + ((mode == 0) ? 0 : 2),
          (mode == 0 || mode == 4) ? "R5" : "R6", "reads after completion", m_reads, m_post);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int el;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(bus_ce_n && bus_oe_n && bus_we_n, "R11", "strobes in reset",
        {bus_ce_n, bus_oe_n, bus_we_n}, 3'b111);
    chk(!done && !error, "R11", "done/error in reset", {done, error}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_ce_n && bus_oe_n && bus_we_n && !done && !error, "R11", "after reset",
        {bus_ce_n, bus_oe_n, bus_we_n, done, error}, 5'b11100);

    // Directed: R1 program, R2 each erase, R5 DQ6 path, R6 confirm paths
    run_op(0, 20'h12345, 16'h00C3, 0, 60, 0, 0, el);
    run_op(1, 20'h0F800, 16'h0000, 0, 80, 0, 0, el);
    run_op(2, 20'hA8000, 16'h0000, 0, 80, 0, 0, el);
    run_op(3, 20'h00000, 16'h0000, 0, 90, 0, 0, el);
    run_op(0, 20'h00777, 16'h5A5A, 4, 70, 0, 0, el);
    run_op(0, 20'h00778, 16'h8001, 1, 50, 0, 0, el);
    run_op(1, 20'h00800, 16'h0000, 2, 50, 0, 1, el);
    // R10: start while busy is ignored
    run_op(0, 20'h0ABCD, 16'h1234, 0, 60, 1, 0, el);

    // R7, R8: limits
    run_op(0, 20'h00010, 16'h00FF, 3, 0, 0, 1, el);
    chk(el >= TO_PROG && el <= TO_PROG + 200, "R7", "program limit cycles", el, TO_PROG);
    run_op(2, 20'h10000, 16'h0000, 3, 0, 0, 1, el);
    chk(el >= TO_ERASE && el <= TO_ERASE + 200, "R8", "erase limit cycles", el, TO_ERASE);
    run_op(3, 20'h00000, 16'h0000, 3, 0, 0, 1, el);
    chk(el >= TO_CHIP && el <= TO_CHIP + 200, "R8", "chip limit cycles", el, TO_CHIP);

    // Constrained random mix
    for (int n = 0; n < 24; n++) begin
      int op, md, bl;
      op = int'($urandom % 4);
      case ($urandom % 4)
        0: md = 0;
        1: md = 1;
        2: md = 2;
        default: md = 4;
      endcase
      bl = 40 + int'($urandom % 300);
      run_op(op, AW'($urandom), DW'($urandom), md, bl, 0, (md == 2), el);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule